// File: doc/BRIEF.md
# Single-Target Platform Interrupt Controller

This block collects level-sensitive interrupt requests from a set of peripheral sources and presents one external interrupt line to a hart. Each source carries a small programmable priority and an enable bit, and the target has a priority threshold. The line is raised while at least one source is pending and enabled and its priority lies strictly above the threshold.

Software reads the claim/complete word to obtain the ID of the best waiting source and so take ownership of it. It writes that ID back to the same word when the handler is finished. While a source is claimed its pending bit cannot be set. A request that is still active during that time is kept in a hidden bit, and the source raises again when it is completed, provided its input is still high.

All registers are 32-bit words in a 1 KiB window. The pending, priority, enable, threshold and claim/complete words sit at fixed offsets. Source-mode words read as zero.

Top module: `plic_core`

## Requirements
- R1: While source i (1..NSRC-1) is not claimed, a high input sets its pending bit in the next cycle. While it is claimed, a high input leaves the pending bit clear. Pending bit i is read at bit i%32 of the word at byte offset 0x000 + 4*(i/32).
- R2: A low input clears the hidden bit of its source. A completion re-raises the pending bit only if the hidden bit is set and the input is still high in the cycle of the completion write.
- R3: A read of byte offset 0x31C returns the held winning ID in the same cycle. The read then clears that source's pending bit, marks it claimed and zeroes the held ID, so irq_o is low in the cycle after the read. A read that returns 0 has no side effect.
- R4: A write of ID n to 0x31C clears the claimed mark of n if n is claimed. If n is not claimed, or n >= NSRC, the write changes nothing.
- R5: A source is eligible only when it is pending, enabled and its priority is strictly greater than the threshold. ID 0 means that no source is eligible.
- R6: Among eligible sources the highest priority wins. On equal priority the lowest ID wins.
- R7: The priority word at byte offset 0x030 + 4*n belongs to source n+1 and keeps only bits [2:0] of a write. The threshold word at 0x318 keeps only bits [1:0].
- R8: Pending words are read-only and ignore writes. Source-mode words 0x018..0x02C and unmapped offsets read 0. Enable bit i is bit i%32 of the word at 0x300 + 4*(i/32) and reads back as written.
- R9: After reset the threshold, the held claim ID, all priorities, enables, pending and claimed bits are 0, and irq_o is low.
- R10: The held winner and irq_o are registered. They reflect the register and pending state of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level interrupt inputs; bit 0 unused |
| bus_valid_i | input | 1 | Access strobe, one access per cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 10 | Byte address in the window; bits [1:0] ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | External interrupt request to the hart |

## Verification
Two pairs of events can fall in the same cycle. In the first, a completion write arrives in the very cycle the source input falls, so the hidden bit and the level disagree. The bench drops the source in the same operation as the completion write and expects the source not to return. In the second, a claim read lands while a claimed source stays high, or while other sources rise. Directed sequences provoke both cases, and random source toggling mixed with bus traffic repeats them. Every read value and the interrupt line are compared each cycle against a bench model built from the requirements.

// File: rtl/plic_pkg.sv
package plic_pkg;
  // Word offsets (byte offset / 4) of the register regions
  localparam int OFS_PEND  = 0;
  localparam int OFS_MODE  = 6;
  localparam int OFS_PRIO  = 12;
  localparam int OFS_EN    = 192;
  localparam int OFS_THR   = 198;
  localparam int OFS_CLAIM = 199;

  typedef enum logic [2:0] {
    RG_NONE, RG_PEND, RG_MODE, RG_PRIO, RG_EN, RG_THR, RG_CLAIM
  } region_e;

  // Map a word index to its register region
  function automatic region_e region_of(int w, int nwords, int nprio);
    if (w < OFS_MODE)             return (w - OFS_PEND < nwords) ? RG_PEND : RG_NONE;
    if (w < OFS_PRIO)             return RG_MODE;
    if (w < OFS_PRIO + nprio)     return RG_PRIO;
    if (w >= OFS_EN && w < OFS_EN + nwords) return RG_EN;
    if (w == OFS_THR)             return RG_THR;
    if (w == OFS_CLAIM)           return RG_CLAIM;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway #(
  parameter int NSRC = 32,
  parameter int IDW  = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            claim_fire_i,
  input  logic [IDW-1:0]  claim_id_i,
  input  logic            done_fire_i,
  input  logic [IDW-1:0]  done_id_i,
  output logic [NSRC-1:0] pending_o
);
  logic [NSRC-1:0] pending_q, claimed_q, hidden_q;
  logic [NSRC-1:0] pending_d, claimed_d, hidden_d;
  logic [NSRC-1:0] claim_hit, done_hit;

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      claim_hit[i] = (i != 0) && claim_fire_i && (int'(claim_id_i) == i);
      done_hit[i]  = (i != 0) && done_fire_i && (int'(done_id_i) == i) && claimed_q[i];
      if (i == 0) begin
        pending_d[i] = 1'b0;
        claimed_d[i] = 1'b0;
        hidden_d[i]  = 1'b0;
      end else begin
        if (claim_hit[i])                                 pending_d[i] = 1'b0;
        else if (done_hit[i] && hidden_q[i] && src_i[i])  pending_d[i] = 1'b1;
        else if (src_i[i] && !claimed_q[i])               pending_d[i] = 1'b1;
        else                                              pending_d[i] = pending_q[i];
        claimed_d[i] = claim_hit[i] | (claimed_q[i] & ~done_hit[i]);
        hidden_d[i]  = src_i[i] & claimed_q[i] & ~done_hit[i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= '0;
      claimed_q <= '0;
      hidden_q  <= '0;
    end else begin
      pending_q <= pending_d;
      claimed_q <= claimed_d;
      hidden_q  <= hidden_d;
    end
  end

  assign pending_o = pending_q;

  // R3: a claim marks the source claimed and drops its pending bit
  a_r3_claim_marks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_fire_i && claim_id_i != '0) |=>
      (claimed_q[$past(claim_id_i)] && !pending_q[$past(claim_id_i)]));

  for (genvar g = 1; g < NSRC; g++) begin : g_chk
    // R1: pending never rises while the source stays claimed
    a_r1_no_pend_while_claimed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claimed_q[g] && !done_hit[g]) |=> !$rose(pending_q[g]));
    // R2: a low input leaves no hidden request behind
    a_r2_hidden_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !src_i[g] |=> !hidden_q[g]);
  end
endmodule

// File: rtl/plic_arbiter.sv
module plic_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int THR_W  = 2,
  parameter int IDW    = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC-1:0]        pending_i,
  input  logic [NSRC-1:0]        enable_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  logic [THR_W-1:0]       thr_i,
  input  logic                   clr_i,
  output logic [IDW-1:0]         best_o,
  output logic                   irq_o
);
  logic [NSRC-1:0] elig_w;
  logic [IDW-1:0]  best_q;

  // Ascending scan with strict compare: lowest ID keeps a tie
  function automatic logic [IDW-1:0] pick(logic [NSRC-1:0] elig,
                                          logic [NSRC*PRIO_W-1:0] prio);
    logic [IDW-1:0]    id = '0;
    logic [PRIO_W-1:0] top = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (elig[i] && prio[i*PRIO_W +: PRIO_W] > top) begin
        id  = IDW'(i);
        top = prio[i*PRIO_W +: PRIO_W];
      end
    end
    return id;
  endfunction

  always_comb begin
    for (int i = 0; i < NSRC; i++)
      elig_w[i] = (i != 0) && pending_i[i] && enable_i[i] &&
                  (prio_i[i*PRIO_W +: PRIO_W] > PRIO_W'(thr_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    best_q <= '0;
    else if (clr_i) best_q <= '0;
    else            best_q <= pick(elig_w, prio_i);
  end

  assign best_o = best_q;
  assign irq_o  = (best_q != '0);

  // R3: the held ID is zero right after a claim read
  a_r3_zero_after_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (best_q == '0));
  // R5: a nonzero winner was eligible in the cycle it was chosen
  a_r5_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_q != '0) |-> ((($past(elig_w) >> best_q) & NSRC'(1)) != '0));
endmodule

// File: rtl/plic_core.sv
module plic_core #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int THR_W  = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_valid_i,
  input  logic            bus_write_i,
  input  logic [9:0]      bus_addr_i,
  input  logic [31:0]     bus_wdata_i,
  output logic [31:0]     bus_rdata_o,
  output logic            irq_o
);
  import plic_pkg::*;

  localparam int IDW    = $clog2(NSRC);
  localparam int NWORDS = (NSRC + 31) / 32;

  logic [PRIO_W-1:0]      prio_q [NSRC];
  logic [NSRC-1:0]        en_q;
  logic [THR_W-1:0]       thr_q;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NSRC-1:0]        pending;
  logic [IDW-1:0]         best;

  int      widx, psrc, eword;
  region_e rg;
  logic    claim_fire, done_fire;

  assign widx  = int'(bus_addr_i[9:2]);
  assign rg    = region_of(widx, NWORDS, NSRC - 1);
  assign psrc  = widx - OFS_PRIO + 1;
  assign eword = widx - OFS_EN;

  assign claim_fire = bus_valid_i && !bus_write_i && (rg == RG_CLAIM);
  assign done_fire  = bus_valid_i && bus_write_i && (rg == RG_CLAIM) &&
                      (bus_wdata_i < 32'(NSRC));

  // Bit b of word w of a packed per-source vector
  function automatic logic [31:0] word_of(logic [NSRC-1:0] v, int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++)
      if (w * 32 + b < NSRC) r[b] = v[w * 32 + b];
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < NSRC; i++) prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_valid_i && !bus_write_i) begin
      unique case (rg)
        RG_PEND:  bus_rdata_o = word_of(pending, widx - OFS_PEND);
        RG_PRIO:  bus_rdata_o = 32'(prio_q[psrc]);
        RG_EN:    bus_rdata_o = word_of(en_q, eword);
        RG_THR:   bus_rdata_o = 32'(thr_q);
        RG_CLAIM: bus_rdata_o = 32'(best);
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      en_q  <= '0;
      thr_q <= '0;
    end else if (bus_valid_i && bus_write_i) begin
      unique case (rg)
        RG_PRIO: prio_q[psrc] <= bus_wdata_i[PRIO_W-1:0];
        RG_EN: begin
          for (int i = 0; i < NSRC; i++)
            if (i / 32 == eword) en_q[i] <= bus_wdata_i[i % 32];
        end
        RG_THR:  thr_q <= bus_wdata_i[THR_W-1:0];
        default: ;
      endcase
    end
  end

  plic_gateway #(.NSRC(NSRC), .IDW(IDW)) u_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .src_i        (src_i),
    .claim_fire_i (claim_fire),
    .claim_id_i   (best),
    .done_fire_i  (done_fire),
    .done_id_i    (bus_wdata_i[IDW-1:0]),
    .pending_o    (pending)
  );

  plic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W), .THR_W(THR_W), .IDW(IDW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pending_i (pending),
    .enable_i  (en_q),
    .prio_i    (prio_flat),
    .thr_i     (thr_q),
    .clr_i     (claim_fire),
    .best_o    (best),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/plic_core_test.sv
module plic_core_test;
  localparam int NSRC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_r = '0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  always #4 clk = ~clk;  // 125 MHz

  plic_core #(.NSRC(NSRC), .PRIO_W(3), .THR_W(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src_r),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // bench model state
  logic [31:0] m_pend, m_clm, m_hid, m_en;
  logic [31:0] n_pend, n_clm, n_hid, n_en;
  int m_prio[NSRC], n_prio[NSRC];
  int m_thr, n_thr, m_best, n_best;
  logic [31:0] last_rd;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pend = '0; m_clm = '0; m_hid = '0; m_en = '0; m_thr = 0; m_best = 0;
    for (int i = 0; i < NSRC; i++) m_prio[i] = 0;
  endtask

  // Winner per R5/R6: descending scan, >= lets the lower ID take a tie
  function automatic int model_pick();
    int bid = 0, bp = 0;
    for (int i = NSRC - 1; i >= 1; i--)
      if (m_pend[i] && m_en[i] && m_prio[i] > m_thr && m_prio[i] >= bp) begin
        bid = i; bp = m_prio[i];
      end
    return bid;
  endfunction

  function automatic logic [31:0] model_read(logic [9:0] a);
    int w = int'(a[9:2]);
    if (w < 6)            return (w == 0) ? m_pend : 32'h0;
    if (w < 12)           return 32'h0;
    if (w < 12 + NSRC - 1) return 32'(m_prio[w - 11]);
    if (w == 192)         return m_en;
    if (w == 198)         return 32'(m_thr);
    if (w == 199)         return 32'(m_best);
    return 32'h0;
  endfunction

  function automatic string tag_of(logic [9:0] a);
    int w = int'(a[9:2]);
    if (w < 6)   return "R1 pending read";
    if (w < 12)  return "R8 mode read";
    if (w < 43)  return "R7 priority read";
    if (w == 192) return "R8 enable read";
    if (w == 198) return "R7 threshold read";
    if (w == 199) return "R3 claim read";
    return "R8 unmapped read";
  endfunction

  task automatic model_next(bit v, bit w, logic [9:0] a, logic [31:0] d);
    bit claim = v && !w && a[9:2] == 8'd199;
    bit done  = v && w && a[9:2] == 8'd199 && d < NSRC;
    int aw = int'(a[9:2]);
    n_pend = m_pend; n_clm = m_clm; n_hid = m_hid; n_en = m_en; n_thr = m_thr;
    for (int i = 0; i < NSRC; i++) n_prio[i] = m_prio[i];
    for (int i = 1; i < NSRC; i++) begin
      bit ch = claim && m_best == i;
      bit dh = done && d == i && m_clm[i];
      if (ch)                              n_pend[i] = 1'b0;
      else if (dh && m_hid[i] && src_r[i]) n_pend[i] = 1'b1;
      else if (src_r[i] && !m_clm[i])      n_pend[i] = 1'b1;
      n_clm[i] = ch ? 1'b1 : (dh ? 1'b0 : m_clm[i]);
      n_hid[i] = src_r[i] && m_clm[i] && !dh;
    end
    if (v && w) begin
      if (aw >= 12 && aw < 12 + NSRC - 1) n_prio[aw - 11] = int'(d & 32'h7);
      if (aw == 192) n_en = d;
      if (aw == 198) n_thr = int'(d & 32'h3);
    end
    n_best = claim ? 0 : model_pick();
  endtask

  task automatic model_commit();
    m_pend = n_pend; m_clm = n_clm; m_hid = n_hid; m_en = n_en; m_thr = n_thr;
    for (int i = 0; i < NSRC; i++) m_prio[i] = n_prio[i];
    m_best = n_best;
  endtask

  // One bus cycle; called at a falling edge
  task automatic op(bit v, bit w, logic [9:0] a, logic [31:0] d);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    #1;
    last_rd = bus_rdata;
    if (v && !w) chk(tag_of(a), last_rd, model_read(a));
    model_next(v, w, a, d);
    @(posedge clk); #1;
    model_commit();
    chk("R10 irq timing", {31'b0, irq}, {31'b0, m_best != 0});
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [9:0] a);      op(1, 0, a, 32'h0); endtask
  task automatic wr(logic [9:0] a, logic [31:0] d); op(1, 1, a, d); endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) op(0, 0, 10'h0, 32'h0); endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk("R9 irq after reset", {31'b0, irq}, 32'h0);
    rd(10'h318); chk("R9 threshold reset", last_rd, 32'h0);
    rd(10'h31C); chk("R9 claim reset", last_rd, 32'h0);
    rd(10'h040); chk("R9 priority reset", last_rd, 32'h0);
    rd(10'h300); chk("R9 enable reset", last_rd, 32'h0);

    // R7: field widths and priority word mapping
    wr(10'h038, 32'hFA); rd(10'h038); chk("R7 prio keeps 3 bits", last_rd, 32'h2);
    rd(10'h034); chk("R7 prio word maps n+1", last_rd, 32'h0);
    wr(10'h318, 32'hFE); rd(10'h318); chk("R7 threshold keeps 2 bits", last_rd, 32'h2);

    // R8: read-only and empty regions
    wr(10'h000, 32'hFFFF_FFFF); rd(10'h000); chk("R8 pending read-only", last_rd, 32'h0);
    wr(10'h018, 32'hFFFF); rd(10'h018); chk("R8 mode word zero", last_rd, 32'h0);
    rd(10'h3F0); chk("R8 unmapped zero", last_rd, 32'h0);
    wr(10'h300, 32'hFFFF_FFFE); rd(10'h300); chk("R8 enable readback", last_rd, 32'hFFFF_FFFE);

    // R5: strict threshold compare (source 3, prio 2, threshold 2)
    src_r[3] = 1'b1; idle(3);
    rd(10'h000); chk("R1 level sets pending", last_rd, 32'h8);
    chk("R5 prio equal to threshold", {31'b0, irq}, 32'h0);
    wr(10'h318, 32'h1); idle(2);
    chk("R5 prio above threshold", {31'b0, irq}, 32'h1);

    // R3: claim and its side effects; source 3 stays high
    rd(10'h31C); chk("R3 claim returns id", last_rd, 32'h3);
    chk("R3 irq low after claim", {31'b0, irq}, 32'h0);
    idle(2);
    rd(10'h000); chk("R1 no pending while claimed", last_rd, 32'h0);
    // R2: completion in the same cycle the source drops
    src_r[3] = 1'b0; wr(10'h31C, 32'h3); idle(2);
    rd(10'h000); chk("R2 dropped source not re-raised", last_rd, 32'h0);
    chk("R2 irq stays low", {31'b0, irq}, 32'h0);

    // R6: priority order and ties (5 and 9 at prio 4, 12 at prio 3)
    wr(10'h318, 32'h0);
    wr(10'h040, 32'h4); wr(10'h050, 32'h4); wr(10'h05C, 32'h3);
    src_r[5] = 1'b1; src_r[9] = 1'b1; src_r[12] = 1'b1; idle(3);
    rd(10'h31C); chk("R6 tie goes to lowest id", last_rd, 32'h5);
    idle(2);
    rd(10'h31C); chk("R6 next equal priority", last_rd, 32'h9);
    // R4: completion while still high re-raises via the hidden bit
    wr(10'h31C, 32'h9); idle(2);
    rd(10'h31C); chk("R4 completed source re-raised", last_rd, 32'h9);
    wr(10'h31C, 32'd40); wr(10'h31C, 32'd12); idle(1);
    rd(10'h000); chk("R4 unclaimed/out-of-range complete ignored", last_rd, 32'h1000);
    wr(10'h31C, 32'h5); wr(10'h31C, 32'h9);
    src_r = '0; idle(2);

    // random phase
    void'($urandom(32'd20240611));
    for (int it = 0; it < 1500; it++) begin
      int kind = int'($urandom_range(0, 7));
      if ($urandom_range(0, 3) == 0) src_r[$urandom_range(1, NSRC - 1)] ^= 1'b1;
      case (kind)
        0: idle(1);
        1: begin
          logic [9:0] addrs[8] = '{10'h000, 10'h004, 10'h020, 10'h03C,
                                   10'h300, 10'h318, 10'h31C, 10'h3FC};
          rd(addrs[$urandom_range(0, 7)]);
        end
        2: wr(10'h030 + 10'(4 * $urandom_range(0, NSRC - 2)), $urandom);
        3: wr(10'h300, $urandom | 32'hAAAA_AAAA);
        4: wr(10'h318, $urandom);
        5, 6: rd(10'h31C);
        default: begin
          int id = int'($urandom_range(0, 35));
          for (int t = 0; t < 8; t++) begin
            int c = int'($urandom_range(1, NSRC - 1));
            if (m_clm[c]) id = c;
          end
          wr(10'h31C, 32'(id));
        end
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule